// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Readout Controller

This block sits on the host side of a read-only, pin-configured sigma-delta converter. The converter is reached over two wires: a serial clock that the block drives and one input line that the converter uses both as its ready flag and as its serial data. While the converter is powered, the block watches that line. When the line goes low, the block clocks out one 32-bit frame. The frame holds a 24-bit conversion result, most significant bit first, followed by an 8-bit status byte. The block checks the status byte against a masked expected value and recodes the result from offset binary to two's complement. Each frame then produces either a one-cycle `valid_o` strobe or a one-cycle `stat_err_o` strobe.

The block also drives the converter's active-low power-down/reset pin, its gain pin and its rate pin. After a reset release or a change to either select pin, the converter's output is not yet settled. For that time the block reads frames to clear the ready flag but discards their contents. A watchdog reports a converter that has gone silent.

Top module: `adc_readout`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises: `sclk_o` is 1, `pdrst_n_o` is 0, and `busy_o`, `valid_o`, `stat_err_o` and `timeout_o` are 0.
- R2: `pdrst_n_o` goes to 0 in the cycle after `pwr_down_i` is 1 and stays 0 while `pwr_down_i` is 1. Once `pwr_down_i` is 0 (or reset ends), `pdrst_n_o` stays 0 for RST_MIN more cycles before it rises.
- R3: A frame starts only while `pdrst_n_o` is 1, the block is idle, and the ready/data line is seen low. A frame has exactly 32 falling edges of `sclk_o`. `sclk_o` is 1 whenever `busy_o` is 0.
- R4: Inside a frame, each low phase of `sclk_o` lasts DIV system cycles, and each high phase between two bits lasts DIV cycles. The line is sampled when `sclk_o` rises.
- R5: Bits arrive most significant first. On an accepted frame, `data_o` is frame bits 31..8 with bit 31 inverted (offset binary to two's complement; raw 0x800000 reads as 0). `status_o` is frame bits 7..0.
- R6: A frame is rejected when ((status XOR `stat_exp_i`) AND `stat_mask_i`) is non-zero. A rejected frame pulses `stat_err_o` for one cycle, updates `status_o`, leaves `data_o` unchanged and gives no `valid_o`. `valid_o` and `stat_err_o` are never 1 together.
- R7: A change on `cfg_gain_i` or `cfg_filter_i` starts a discard window. The window is SETTLE_SLOW cycles when the new `cfg_filter_i` is 1 (slow rate) and SETTLE_FAST cycles when it is 0. A frame that completes inside the window, or in the cycle of the change, gives neither `valid_o` nor `stat_err_o`.
- R8: When `pdrst_n_o` rises, a discard window of the rate's settle time plus WAKE cycles starts. Frames that complete inside it are dropped silently.
- R9: While powered and idle, `timeout_o` pulses for one cycle after every WDOG cycles without a frame start.
- R10: After a frame's last bit, the block stays busy and starts no new frame until the line has been seen high.
- R11: `gain_o` and `filter_o` follow `cfg_gain_i` and `cfg_filter_i` one cycle later (`gain_o`=1 means gain 128, `filter_o`=1 means the slow rate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rdy_dout_i | input | 1 | Shared ready (low) / serial data line from the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| pdrst_n_o | output | 1 | Active-low power-down/reset to the converter |
| gain_o | output | 1 | Gain select pin (1 = x128) |
| filter_o | output | 1 | Rate select pin (1 = slow rate) |
| pwr_down_i | input | 1 | Hold the converter in power-down |
| cfg_gain_i | input | 1 | Requested gain select |
| cfg_filter_i | input | 1 | Requested rate select |
| stat_mask_i | input | 8 | Status bits that are compared |
| stat_exp_i | input | 8 | Expected status value |
| busy_o | output | 1 | A frame is being read or drained |
| valid_o | output | 1 | One-cycle strobe: accepted result |
| data_o | output | 24 | Last accepted result, two's complement |
| status_o | output | 8 | Status byte of the last judged frame |
| stat_err_o | output | 1 | One-cycle strobe: status mismatch |
| timeout_o | output | 1 | One-cycle strobe: no ready within WDOG cycles |

## Verification
Two functions can meet in the same frame: the end of a frame read and the start of a discard window caused by a select-pin change or a power-up. The bench provokes this in two ways. It changes the select input at the moment a ready frame is offered, and it changes the gain select halfway through a frame. In both cases the completing frame must produce no strobe of either kind, and a frame offered after the window must be accepted. The bench also offers a ready low while powered down and holds the line low after a frame, to show that neither starts a read.

// File: rtl/adc_readout.sv
module adc_readout #(
  parameter int DIV         = 10,
  parameter int RST_MIN     = 16,
  parameter int SETTLE_FAST = 12_000_000,
  parameter int SETTLE_SLOW = 30_000_000,
  parameter int WAKE        = 100_000,
  parameter int WDOG        = 40_000_000,
  parameter int CNT_W       = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rdy_dout_i,
  output logic        sclk_o,
  output logic        pdrst_n_o,
  output logic        gain_o,
  output logic        filter_o,
  input  logic        pwr_down_i,
  input  logic        cfg_gain_i,
  input  logic        cfg_filter_i,
  input  logic [7:0]  stat_mask_i,
  input  logic [7:0]  stat_exp_i,
  output logic        busy_o,
  output logic        valid_o,
  output logic [23:0] data_o,
  output logic [7:0]  status_o,
  output logic        stat_err_o,
  output logic        timeout_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0]    PH_END  = PW'(DIV - 1);
  localparam logic [CNT_W-1:0] RST_END = CNT_W'(RST_MIN - 1);
  localparam logic [CNT_W-1:0] WD_END  = CNT_W'(WDOG - 1);
  localparam logic [CNT_W-1:0] LD_FAST = CNT_W'(SETTLE_FAST);
  localparam logic [CNT_W-1:0] LD_SLOW = CNT_W'(SETTLE_SLOW);
  localparam logic [CNT_W-1:0] LD_WAKE = CNT_W'(WAKE);

  typedef enum logic [1:0] {IDLE, SHIFT, DONE, DRAIN} st_t;
  st_t st;

  logic             rdy_m, rdy_s;
  logic             pdrst_q, gain_q, filt_q, sclk_q;
  logic [CNT_W-1:0] pd_cnt, blank, wd_cnt;
  logic [PW-1:0]    ph;
  logic [4:0]       bitn;
  logic [31:0]      sh;
  logic             valid_q, err_q, tmo_q;
  logic [23:0]      data_q;
  logic [7:0]       stat_q;

  wire cfg_chg = (cfg_gain_i != gain_q) || (cfg_filter_i != filt_q);
  wire pd_rel  = !pwr_down_i && !pdrst_q && (pd_cnt == RST_END);
  wire [CNT_W-1:0] settle = cfg_filter_i ? LD_SLOW : LD_FAST;
  wire stat_bad = |((sh[7:0] ^ stat_exp_i) & stat_mask_i);

  assign sclk_o     = sclk_q;
  assign pdrst_n_o  = pdrst_q;
  assign gain_o     = gain_q;
  assign filter_o   = filt_q;
  assign busy_o     = (st != IDLE);
  assign valid_o    = valid_q;
  assign stat_err_o = err_q;
  assign timeout_o  = tmo_q;
  assign data_o     = data_q;
  assign status_o   = stat_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdy_m <= 1'b1;
      rdy_s <= 1'b1;
      gain_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      rdy_m <= rdy_dout_i;
      rdy_s <= rdy_m;
      gain_q <= cfg_gain_i;
      filt_q <= cfg_filter_i;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pdrst_q <= 1'b0;
      pd_cnt  <= '0;
    end else if (pwr_down_i) begin
      pdrst_q <= 1'b0;
      pd_cnt  <= '0;
    end else if (!pdrst_q) begin
      if (pd_cnt == RST_END) pdrst_q <= 1'b1;
      else                   pd_cnt  <= pd_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              blank <= '0;
    else if (pd_rel)         blank <= settle + LD_WAKE;
    else if (cfg_chg)        blank <= settle;
    else if (blank != '0)    blank <= blank - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_cnt <= '0;
      tmo_q  <= 1'b0;
    end else begin
      tmo_q <= 1'b0;
      if (!pdrst_q || st != IDLE) wd_cnt <= '0;
      else if (wd_cnt == WD_END) begin
        wd_cnt <= '0;
        tmo_q  <= 1'b1;
      end else wd_cnt <= wd_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= IDLE;
      sclk_q <= 1'b1;
      ph     <= '0;
      bitn   <= '0;
      sh     <= '0;
    end else if (!pdrst_q) begin
      st     <= IDLE;
      sclk_q <= 1'b1;
      ph     <= '0;
    end else begin
      case (st)
        IDLE: if (!rdy_s) begin
          st     <= SHIFT;
          sclk_q <= 1'b0;
          ph     <= '0;
          bitn   <= '0;
        end
        SHIFT: if (ph == PH_END) begin
          ph     <= '0;
          sclk_q <= ~sclk_q;
          if (!sclk_q) begin
            sh   <= {sh[30:0], rdy_s};
            bitn <= bitn + 1'b1;
            if (bitn == 5'd31) st <= DONE;
          end
        end else ph <= ph + 1'b1;
        DONE:  st <= DRAIN;
        default: if (rdy_s) st <= IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
      stat_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      if (st == DONE && pdrst_q && blank == '0 && !cfg_chg) begin
        stat_q <= sh[7:0];
        if (stat_bad) err_q <= 1'b1;
        else begin
          valid_q <= 1'b1;
          data_q  <= {~sh[31], sh[30:8]};
        end
      end
    end

  assert_pd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |=> !pdrst_n_o);
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sclk_o);
  assert_low_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |=> !sclk_o);
  assert_one_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && stat_err_o));
  assert_cfg_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_o != $past(gain_o) || filter_o != $past(filter_o)) |-> !valid_o);
  assert_tmo_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
endmodule

// File: tb/test_adc_readout.sv
module test_adc_readout;
  localparam int DIV = 10, RST_MIN = 20, SF = 300, SS = 700, WK = 100, WD = 3000;

  logic clk = 1'b0, rst_n = 1'b0, line = 1'b1;
  logic pwr_down = 1'b0, cfg_gain = 1'b0, cfg_filter = 1'b0;
  logic [7:0] mask = 8'h0F, expv = 8'h0A;
  logic sclk_o, pdrst_n_o, gain_o, filter_o, busy_o, valid_o, stat_err_o, timeout_o;
  logic [23:0] data_o;
  logic [7:0] status_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  adc_readout #(.DIV(DIV), .RST_MIN(RST_MIN), .SETTLE_FAST(SF), .SETTLE_SLOW(SS),
    .WAKE(WK), .WDOG(WD), .CNT_W(32)) i_adc_readout (
    .clk(clk), .rst_n(rst_n), .rdy_dout_i(line), .sclk_o(sclk_o), .pdrst_n_o(pdrst_n_o),
    .gain_o(gain_o), .filter_o(filter_o), .pwr_down_i(pwr_down), .cfg_gain_i(cfg_gain),
    .cfg_filter_i(cfg_filter), .stat_mask_i(mask), .stat_exp_i(expv), .busy_o(busy_o),
    .valid_o(valid_o), .data_o(data_o), .status_o(status_o), .stat_err_o(stat_err_o),
    .timeout_o(timeout_o));

  // converter model
  logic [31:0] mframe;
  int midx = 0, mrises = 0;
  bit armed = 0, hold_low = 0;
  always @(negedge sclk_o) if (armed && midx >= 0) begin
    #20 line = mframe[midx];
    midx = midx - 1;
  end
  always @(posedge sclk_o) if (armed) begin
    mrises = mrises + 1;
    if (mrises == 32) begin
      armed = 0;
      #30 line = hold_low ? 1'b0 : 1'b1;
    end
  end

  // serial clock monitor
  int run = 0, falls = 0, rises_f = 0, lowbad = 0, highbad = 0;
  logic prev_s = 1'b1, prev_b = 1'b0;
  always @(negedge clk) begin
    if (sclk_o !== prev_s) begin
      if (prev_s == 1'b0) begin
        if (run != DIV) lowbad++;
        rises_f++;
      end else begin
        falls++;
        if (rises_f >= 1 && rises_f < 32 && run != DIV) highbad++;
      end
      run = 1;
    end else run++;
    if (busy_o && !prev_b) rises_f = 0;
    prev_s = sclk_o;
    prev_b = busy_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [23:0] raw, input logic [7:0] st);
    mframe = {raw, st};
    midx = 31;
    mrises = 0;
    falls = 0;
    armed = 1;
    line = 1'b0;
  endtask

  task automatic wait_res(input int n, output bit gv, output bit ge);
    gv = 0; ge = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (valid_o) gv = 1;
      if (stat_err_o) ge = 1;
      if (gv || ge) break;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
    cyc(5);
  endtask

  task automatic t_reset();
    int n;
    cyc(1);
    chk("R1 sclk", sclk_o, 1); chk("R1 pdrst", pdrst_n_o, 0);
    chk("R1 busy", busy_o, 0); chk("R1 strobes", {valid_o, stat_err_o, timeout_o}, 0);
    rst_n = 1'b1;
    n = 0;
    while (!pdrst_n_o && n < 100) begin @(negedge clk); n++; end
    chk("R2 release delay ok", (n >= RST_MIN && n <= RST_MIN + 1), 1);
    cyc(SF + WK + 20);
  endtask

  task automatic t_frame(input logic [23:0] raw, input logic [7:0] st, input bit acc,
                         input logic [23:0] exp_d, input string tag);
    bit gv, ge;
    logic [23:0] old_d;
    old_d = data_o;
    lowbad = 0; highbad = 0;
    arm(raw, st);
    wait_res(1500, gv, ge);
    chk({tag, " valid"}, gv, acc);
    chk({tag, " err"}, ge, !acc);
    chk({tag, " R5 status"}, status_o, st);
    chk({tag, " R5 data"}, data_o, acc ? exp_d : old_d);
    chk({tag, " R3 falls"}, falls, 32);
    chk({tag, " R4 phases"}, lowbad + highbad, 0);
    wait_idle();
  endtask

  task automatic t_hold();
    bit gv, ge;
    hold_low = 1;
    arm(24'h123456, 8'h0A);
    wait_res(1500, gv, ge);
    chk("R10 frame accepted", gv, 1);
    cyc(300);
    chk("R10 still busy", busy_o, 1);
    chk("R10 no restart", falls, 32);
    hold_low = 0;
    line = 1'b1;
    cyc(6);
    chk("R10 idle after high", busy_o, 0);
    cyc(5);
  endtask

  task automatic t_settle();
    bit gv, ge;
    cfg_filter = 1'b1;
    cyc(1);
    chk("R11 filter pin", filter_o, 1);
    arm(24'h800010, 8'h0A);
    wait_res(SS + 100, gv, ge);
    chk("R7 filter change discards", {gv, ge}, 0);
    wait_idle();
    t_frame(24'h800020, 8'h0A, 1, 24'h000020, "R7 after window");
    arm(24'h800030, 8'h0A);
    cyc(300);
    cfg_gain = 1'b1;
    cyc(1);
    chk("R11 gain pin", gain_o, 1);
    wait_res(SS + 100, gv, ge);
    chk("R7 mid-frame gain change discards", {gv, ge}, 0);
    wait_idle();
    t_frame(24'h800040, 8'h0A, 1, 24'h000040, "R7 after gain window");
  endtask

  task automatic t_pd();
    bit gv, ge;
    int n;
    pwr_down = 1'b1;
    cyc(1);
    chk("R2 pdrst low", pdrst_n_o, 0);
    falls = 0;
    line = 1'b0;
    cyc(10);
    chk("R2 held low", pdrst_n_o, 0);
    chk("R3 no read unpowered", {busy_o, 1'(falls != 0)}, 0);
    line = 1'b1;
    cyc(2);
    pwr_down = 1'b0;
    n = 0;
    while (!pdrst_n_o && n < 100) begin @(negedge clk); n++; end
    chk("R2 min low time", (n >= RST_MIN && n <= RST_MIN + 1), 1);
    arm(24'h800050, 8'h0A);
    wait_res(SS + WK + 100, gv, ge);
    chk("R8 wake discard", {gv, ge}, 0);
    wait_idle();
    t_frame(24'h800060, 8'h0A, 1, 24'h000060, "R8 after wake");
  endtask

  task automatic t_wdog();
    int n;
    bit early;
    pwr_down = 1'b1;
    cyc(3);
    pwr_down = 1'b0;
    while (!pdrst_n_o) @(negedge clk);
    n = 0; early = 0;
    while (!timeout_o && n < WD + 50) begin
      @(negedge clk);
      n++;
    end
    early = (n < WD - 2);
    chk("R9 timeout period", (n >= WD - 2 && n <= WD + 2), 1);
    chk("R9 not early", early, 0);
    cyc(1);
    chk("R9 one-cycle pulse", timeout_o, 0);
  endtask

  initial begin
    int wd_t;
    wd_t = 0;
    fork
      begin
        t_reset();
        t_frame(24'h800001, 8'h0A, 1, 24'h000001, "R5 small positive");
        t_frame(24'h7FFFFF, 8'h3A, 1, 24'hFFFFFF, "R5 minus one");
        t_frame(24'h000000, 8'hFA, 1, 24'h800000, "R5 most negative");
        t_frame(24'h654321, 8'h05, 0, 24'h000000, "R6 mismatch");
        mask = 8'h00;
        t_frame(24'hABCDEF, 8'h55, 1, 24'h2BCDEF, "R6 mask zero");
        mask = 8'h0F;
        t_hold();
        t_settle();
        t_pd();
        t_wdog();
      end
      begin
        while (wd_t < 150000) begin @(posedge clk); wd_t++; end
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule